// File: doc/BRIEF.md
# Capability Jump Target Checker

This block validates the target of an indirect jump-and-link made through a capability register. It receives the fields of the source capability that matter for the jump: validity tag, object type, execute permission and address. It also takes the immediate offset, a flag that says whether a link register is written, a flag for the return-address form, the current global interrupt-enable bit and a flag that says whether compressed instructions are present. One cycle after a request strobe it reports pass or fail with a cause code, the jump target, the object type to seal the link with and the interrupt-enable bit that holds after the jump.

Which object types are legal depends on the link form. A jump through a forward or backward sentry switches interrupts on or off, except for the interrupt-inheriting kind. The block does not decompress capabilities, read the register file or enter a trap. The surrounding pipeline uses the cause code to raise the exception and uses the target, link type and interrupt bit to commit the jump.

Top module: `cap_jump_check`

## Requirements
- R1: `done_o` is high in the cycle after a cycle with `req_i` high and low after any cycle with `req_i` low. All results of a request appear with that pulse.
- R2: On success, `pc_o` equals `addr_i + offset_i` (modulo 2^ADDR_W) with bit 0 cleared.
- R3: Cause codes are 0 none, 1 tag clear, 2 seal violation, 3 no execute permission, 4 misaligned. Only the first failing check in the order tag, seal, execute, alignment is reported. `ok_o` is 1 exactly when the cause is 0.
- R4: The misaligned cause (4) arises only when `compressed_i` is 0 and bit 1 of the computed target is 1.
- R5: Object type codes are 0 unsealed, 1 inheriting forward sentry, 2 disabling forward sentry, 3 enabling forward sentry, 4 disabling backward sentry, 5 enabling backward sentry, and 6 and 7 are other sealed types. The type is legal when one of these holds: no link and return form with type 4 or 5; no link and plain form with type 0 or 1; link with type 0 or 1; link and return form with type 0 to 3. Any other type is a seal violation.
- R6: A source with a nonzero object type and a nonzero offset is a seal violation, even when its type is legal for the form.
- R7: On success, `link_otype_o` is 5 when a link is written in the return form and `ie_i` is 1, 4 when the same holds with `ie_i` 0, and 0 in every other case.
- R8: On success, `ie_o` becomes 0 for target type 2 or 4, 1 for type 3 or 5, and equals `ie_i` for type 0 or 1.
- R9: A failed request, or a cycle with no request, leaves `pc_o`, `ie_o` and `link_otype_o` unchanged.
- R10: Reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe, one cycle per jump |
| tag_i | input | 1 | Source capability validity tag |
| otype_i | input | 3 | Source capability object type |
| perm_x_i | input | 1 | Source capability execute permission |
| addr_i | input | ADDR_W | Source capability address |
| offset_i | input | ADDR_W | Immediate offset |
| has_link_i | input | 1 | A link register is written |
| link_ra_i | input | 1 | Return-address form of the jump |
| ie_i | input | 1 | Current global interrupt enable |
| compressed_i | input | 1 | Compressed instructions are supported |
| done_o | output | 1 | Result valid pulse |
| ok_o | output | 1 | Jump allowed |
| cause_o | output | 3 | Exception cause code |
| pc_o | output | ADDR_W | Jump target |
| link_otype_o | output | 3 | Object type for sealing the link |
| ie_o | output | 1 | Interrupt enable after the jump |

## Verification
Every result of a request is due at the edge after the strobe, so the reference model in the bench updates its expected outputs at each rising edge from the inputs present there. It compares them with the design at the following falling edge, one edge after the request. Between requests the model keeps its target, link type and interrupt bit unchanged, so the same per-cycle comparison also checks the holding behaviour. Directed cases read the cause at that same falling edge after the strobe drops.

// File: rtl/cjc_pkg.sv
package cjc_pkg;
  localparam int OT_W    = 3;
  localparam int CAUSE_W = 3;

  localparam logic [OT_W-1:0] OT_UNSEALED  = 3'd0;
  localparam logic [OT_W-1:0] OT_FWD_INH   = 3'd1;
  localparam logic [OT_W-1:0] OT_FWD_OFF   = 3'd2;
  localparam logic [OT_W-1:0] OT_FWD_ON    = 3'd3;
  localparam logic [OT_W-1:0] OT_BWD_OFF   = 3'd4;
  localparam logic [OT_W-1:0] OT_BWD_ON    = 3'd5;

  typedef enum logic [CAUSE_W-1:0] {
    CZ_NONE  = 3'd0,
    CZ_TAG   = 3'd1,
    CZ_SEAL  = 3'd2,
    CZ_EXEC  = 3'd3,
    CZ_ALIGN = 3'd4
  } cause_e;
endpackage

// File: rtl/cjc_target.sv
module cjc_target #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic              compressed_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              misalign_o
);
  localparam logic [ADDR_W-1:0] LSB_CLEAR = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic [ADDR_W-1:0] sum;

  always_comb begin
    sum        = addr_i + offset_i;
    pc_o       = sum & LSB_CLEAR;
    misalign_o = !compressed_i && sum[1];
  end
endmodule

// File: rtl/cjc_seal_rules.sv
module cjc_seal_rules
  import cjc_pkg::*;
(
  input  logic [OT_W-1:0] otype_i,
  input  logic            has_link_i,
  input  logic            link_ra_i,
  input  logic            offset_nz_i,
  output logic            seal_fault_o
);
  logic sealed, plain_ok, back_kind, fwd_range, legal;

  always_comb begin
    sealed    = (otype_i != OT_UNSEALED);
    plain_ok  = (otype_i == OT_UNSEALED) || (otype_i == OT_FWD_INH);
    back_kind = (otype_i == OT_BWD_OFF) || (otype_i == OT_BWD_ON);
    fwd_range = (otype_i <= OT_FWD_ON);
    legal     = (!has_link_i &&  link_ra_i && back_kind)
              | (!has_link_i && !link_ra_i && plain_ok)
              | ( has_link_i && plain_ok)
              | ( has_link_i &&  link_ra_i && fwd_range);
    seal_fault_o = (sealed && offset_nz_i) || !legal;
  end
endmodule

// File: rtl/cjc_irq_link.sv
module cjc_irq_link
  import cjc_pkg::*;
(
  input  logic [OT_W-1:0] otype_i,
  input  logic            has_link_i,
  input  logic            link_ra_i,
  input  logic            ie_i,
  output logic [OT_W-1:0] link_otype_o,
  output logic            ie_next_o
);
  logic turns_off, turns_on;

  always_comb begin
    turns_off = (otype_i == OT_FWD_OFF) || (otype_i == OT_BWD_OFF);
    turns_on  = (otype_i == OT_FWD_ON)  || (otype_i == OT_BWD_ON);
    if (turns_on)       ie_next_o = 1'b1;
    else if (turns_off) ie_next_o = 1'b0;
    else                ie_next_o = ie_i;
    if (has_link_i && link_ra_i) link_otype_o = ie_i ? OT_BWD_ON : OT_BWD_OFF;
    else                         link_otype_o = OT_UNSEALED;
  end
endmodule

// File: rtl/cap_jump_check.sv
module cap_jump_check
  import cjc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              tag_i,
  input  logic [2:0]        otype_i,
  input  logic              perm_x_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic              has_link_i,
  input  logic              link_ra_i,
  input  logic              ie_i,
  input  logic              compressed_i,
  output logic              done_o,
  output logic              ok_o,
  output logic [2:0]        cause_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [2:0]        link_otype_o,
  output logic              ie_o
);
  logic [ADDR_W-1:0] pc_d;
  logic              misalign, seal_fault, pass;
  logic [OT_W-1:0]   link_d;
  logic              ie_d;
  cause_e            cause_d;

  cjc_target #(.ADDR_W(ADDR_W)) u_target (
    .addr_i      (addr_i),
    .offset_i    (offset_i),
    .compressed_i(compressed_i),
    .pc_o        (pc_d),
    .misalign_o  (misalign)
  );

  cjc_seal_rules u_seal (
    .otype_i     (otype_i),
    .has_link_i  (has_link_i),
    .link_ra_i   (link_ra_i),
    .offset_nz_i (offset_i != '0),
    .seal_fault_o(seal_fault)
  );

  cjc_irq_link u_irq (
    .otype_i     (otype_i),
    .has_link_i  (has_link_i),
    .link_ra_i   (link_ra_i),
    .ie_i        (ie_i),
    .link_otype_o(link_d),
    .ie_next_o   (ie_d)
  );

  always_comb begin
    if (!tag_i)          cause_d = CZ_TAG;
    else if (seal_fault) cause_d = CZ_SEAL;
    else if (!perm_x_i)  cause_d = CZ_EXEC;
    else if (misalign)   cause_d = CZ_ALIGN;
    else                 cause_d = CZ_NONE;
    pass = tag_i && !seal_fault && perm_x_i && !misalign;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o       <= 1'b0;
      ok_o         <= 1'b0;
      cause_o      <= '0;
      pc_o         <= '0;
      link_otype_o <= '0;
      ie_o         <= 1'b0;
    end else begin
      done_o <= req_i;
      if (req_i) begin
        ok_o    <= pass;
        cause_o <= cause_d;
        if (pass) begin
          pc_o         <= pc_d;
          link_otype_o <= link_d;
          ie_o         <= ie_d;
        end
      end
    end
  end
endmodule

// File: rtl/cjc_props.sv
module cjc_props #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_i,
  input logic              tag_i,
  input logic              compressed_i,
  input logic              done_o,
  input logic              ok_o,
  input logic [2:0]        cause_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [2:0]        link_otype_o,
  input logic              ie_o
);
  assert_done_after_req_R1: assert property (@(posedge clk) disable iff (rst)
    req_i |=> done_o);
  assert_no_spurious_done_R1: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> !done_o);
  assert_pc_even_R2: assert property (@(posedge clk) disable iff (rst)
    pc_o[0] == 1'b0);
  assert_ok_vs_cause_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (ok_o == (cause_o == 3'd0)));
  assert_tag_first_R3: assert property (@(posedge clk) disable iff (rst)
    (req_i && !tag_i) |=> (cause_o == 3'd1));
  assert_no_align_when_compressed_R4: assert property (@(posedge clk) disable iff (rst)
    (req_i && compressed_i) |=> (cause_o != 3'd4));
  assert_link_code_R7: assert property (@(posedge clk) disable iff (rst)
    (link_otype_o == 3'd0) || (link_otype_o == 3'd4) || (link_otype_o == 3'd5));
  assert_hold_on_tag_fail_R9: assert property (@(posedge clk) disable iff (rst)
    (req_i && !tag_i) |=> ($stable(pc_o) && $stable(ie_o) && $stable(link_otype_o)));
  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> ($stable(pc_o) && $stable(ie_o) && $stable(link_otype_o)));
endmodule

bind cap_jump_check cjc_props #(.ADDR_W(ADDR_W)) u_props (
  .clk         (clk),
  .rst         (rst),
  .req_i       (req_i),
  .tag_i       (tag_i),
  .compressed_i(compressed_i),
  .done_o      (done_o),
  .ok_o        (ok_o),
  .cause_o     (cause_o),
  .pc_o        (pc_o),
  .link_otype_o(link_otype_o),
  .ie_o        (ie_o)
);

// File: tb/cap_jump_check_test.sv
`timescale 1ns/1ps
module cap_jump_check_test;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 0, tag = 0, px = 0, hl = 0, ra = 0, ie = 0, cmp = 0;
  logic [2:0] ot = '0;
  logic [AW-1:0] addr = '0, offs = '0;
  logic done, ok, ie_q;
  logic [2:0] cause, lot;
  logic [AW-1:0] pc;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cap_jump_check #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .req_i(req), .tag_i(tag), .otype_i(ot),
    .perm_x_i(px), .addr_i(addr), .offset_i(offs), .has_link_i(hl),
    .link_ra_i(ra), .ie_i(ie), .compressed_i(cmp), .done_o(done),
    .ok_o(ok), .cause_o(cause), .pc_o(pc), .link_otype_o(lot), .ie_o(ie_q)
  );

  task automatic chk(input string req_tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req_tag, what, act, exp);
    end
  endtask

  // Behavioural reference of the requirements.
  function automatic int ref_cause(bit t, int o, bit x, bit link, bit rform,
                                   bit c, logic [AW-1:0] a, logic [AW-1:0] f);
    logic [AW-1:0] s;
    bit legal;
    s = a + f;
    legal = 0;
    if (!link && rform && (o == 4 || o == 5)) legal = 1;
    if (!link && !rform && (o == 0 || o == 1)) legal = 1;
    if (link && (o == 0 || o == 1)) legal = 1;
    if (link && rform && o <= 3) legal = 1;
    if (!t) return 1;
    if ((o != 0 && f != 0) || !legal) return 2;
    if (!x) return 3;
    if (!c && s[1]) return 4;
    return 0;
  endfunction

  bit m_done, m_ok, m_ie;
  int m_cause, m_link;
  logic [AW-1:0] m_pc;

  always @(posedge clk) begin
    if (rst) begin
      m_done = 0; m_ok = 0; m_ie = 0; m_cause = 0; m_link = 0; m_pc = '0;
    end else begin
      m_done = req;
      if (req) begin
        m_cause = ref_cause(tag, int'(ot), px, hl, ra, cmp, addr, offs);
        m_ok = (m_cause == 0);
        if (m_ok) begin
          m_pc = (addr + offs) & ~32'd1;
          m_link = (hl && ra) ? (ie ? 5 : 4) : 0;
          if (ot == 3 || ot == 5) m_ie = 1;
          else if (ot == 2 || ot == 4) m_ie = 0;
          else m_ie = ie;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R1", "done", done, m_done);
      if (m_done) begin
        chk("R3", "cause", cause, m_cause);
        chk("R3", "ok", ok, m_ok);
      end
      chk("R2 R9", "pc", pc, m_pc);
      chk("R7 R9", "link", lot, m_link);
      chk("R8 R9", "ie", ie_q, m_ie);
    end
  end

  task automatic issue(input bit t, input int o, input bit x, input bit link,
                       input bit rform, input bit ien, input bit c,
                       input logic [AW-1:0] a, input logic [AW-1:0] f);
    @(negedge clk);
    req = 1; tag = t; ot = 3'(o); px = x; hl = link; ra = rform;
    ie = ien; cmp = c; addr = a; offs = f;
    @(negedge clk);
    req = 0;
  endtask

  task automatic directed(input string rq, input int exp_cause,
                          input bit t, input int o, input bit x, input bit link,
                          input bit rform, input bit ien, input bit c,
                          input logic [AW-1:0] a, input logic [AW-1:0] f);
    issue(t, o, x, link, rform, ien, c, a, f);
    chk(rq, "directed cause", cause, exp_cause);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "reset done", done, 0);
    chk("R10", "reset pc", pc, 0);
    chk("R10", "reset ie", ie_q, 0);
    chk("R10", "reset link", lot, 0);
    chk("R10", "reset cause", cause, 0);
    @(negedge clk);
    rst = 0;
    // priority: everything wrong, tag wins
    directed("R3", 1, 0, 7, 0, 0, 0, 0, 0, 32'h2, 32'h4);
    directed("R3", 2, 1, 7, 0, 0, 0, 0, 0, 32'h2, 32'h0);
    directed("R3", 3, 1, 0, 0, 0, 0, 0, 0, 32'h2, 32'h0);
    directed("R4", 4, 1, 0, 1, 0, 0, 0, 0, 32'h2, 32'h0);
    directed("R4", 0, 1, 0, 1, 0, 0, 0, 1, 32'h2, 32'h0);
    directed("R2", 0, 1, 0, 1, 1, 0, 0, 0, 32'h1001, 32'h4);
    // legality table
    directed("R5", 0, 1, 4, 1, 0, 1, 1, 1, 32'h100, 32'h0);
    directed("R5", 2, 1, 1, 1, 0, 1, 1, 1, 32'h100, 32'h0);
    directed("R5", 0, 1, 1, 1, 0, 0, 1, 1, 32'h100, 32'h0);
    directed("R5", 2, 1, 5, 1, 0, 0, 1, 1, 32'h100, 32'h0);
    directed("R5", 0, 1, 3, 1, 1, 1, 0, 1, 32'h100, 32'h0);
    directed("R5", 2, 1, 3, 1, 1, 0, 0, 1, 32'h100, 32'h0);
    directed("R5", 2, 1, 6, 1, 1, 1, 0, 1, 32'h100, 32'h0);
    // sealed with offset
    directed("R6", 2, 1, 1, 1, 1, 0, 1, 1, 32'h100, 32'h8);
    directed("R6", 0, 1, 0, 1, 1, 0, 1, 1, 32'h100, 32'h8);
    // interrupt state and link sealing
    directed("R8", 0, 1, 2, 1, 1, 1, 1, 1, 32'h200, 32'h0);
    directed("R7", 0, 1, 3, 1, 1, 1, 0, 1, 32'h300, 32'h0);
    // failure holds
    directed("R9", 3, 1, 5, 0, 0, 1, 1, 1, 32'h7770, 32'h0);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 400; i++) begin
      issue($urandom_range(0, 7) != 0, $urandom_range(0, 7),
            $urandom_range(0, 5) != 0, $urandom_range(0, 1),
            $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom, ($urandom_range(0, 2) == 0) ? $urandom : 32'h0);
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule